// File: doc/BRIEF.md
# Two-Phase Task Schedule Sequencer

This block drives a set of external computation units, each identified by a task number, through a motor-control style schedule. A run command starts an output phase, in which a list of output-side tasks is issued one at a time through a start strobe and a done handshake. When that list is exhausted the block parks until a selected hardware trigger arrives. The trigger opens an input phase with its own task list. After the input phase the block either loops back into another output phase, while programmed repetitions remain, or raises a schedule-end interrupt and returns to idle.

A single-task mode runs one named task and ends at once. A task-end interrupt can be tied to any task number. An overrun guard watches a PWM interrupt during the output phase; when it is armed, that interrupt aborts the schedule and sets a sticky error flag. A debug pulse marks every task hand-off so the sequence can be watched from outside.

Top module: `sched_seq`

## Requirements
- R1: A run command pulse starts the output phase only when the block is idle, `cfg_enable` is 1 and `cfg_repeat` is non-zero. In any other case it is ignored and no task is started.
- R2: For a schedule value s from 1 to 15, the output list holds each task k in 0..3 whose bit k of s is 1, followed by task 4. The input list holds each task 8+k for every bit k of s that is 1, followed by task 12.
- R3: Schedule value 0 runs only the task named by `cfg_task`, once. It then raises `sched_irq` without waiting for a trigger and without repeating.
- R4: Within a phase the tasks start in ascending number order. Each start is a one-cycle pulse on one bit of `task_start`, and the next start comes only after the `task_done` bit of the running task is seen. A done on any other bit is ignored.
- R5: After the output list completes, the block waits for the trigger chosen by `cfg_trig_sel` (0 selects `trig_a`, 1 selects `trig_b`). The unselected trigger has no effect.
- R6: After each input phase, the block returns to the output phase until `cfg_repeat` passes have run. It then pulses `sched_irq` and goes idle.
- R7: Schedule values 10 to 15 make a single pass whatever non-zero repeat count is set.
- R8: When `cfg_err_en` is 1 and `pwm_irq` is seen during the output phase, the schedule aborts, `sched_irq` pulses and `err_flag` is set. A `pwm_irq` outside the output phase, or with `cfg_err_en` at 0, has no effect.
- R9: `err_flag` stays set until `err_clr` is pulsed. A new error in the same cycle takes precedence over the clear.
- R10: When `cfg_tirq_en` is 1, `task_irq` pulses for one cycle on the done of the task numbered `cfg_tirq_task`.
- R11: `dbg_pulse` is high for exactly the cycle in which a task start strobe is issued.
- R12: After reset all outputs are 0. `sched_irq` and `task_irq` are never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Block enable; the run command is ignored while low |
| cfg_sched | input | 4 | Schedule select, 0 = single task |
| cfg_task | input | 4 | Task run in single-task mode |
| cfg_repeat | input | 4 | Number of passes, 0 = never run |
| cfg_trig_sel | input | 1 | Input-phase trigger select |
| cfg_err_en | input | 1 | Arms the PWM overrun abort |
| cfg_tirq_en | input | 1 | Enables the task-end interrupt |
| cfg_tirq_task | input | 4 | Task whose done raises the task-end interrupt |
| err_clr | input | 1 | Clears the error flag |
| run_cmd | input | 1 | Run command pulse |
| trig_a | input | 1 | Conversion-end trigger A |
| trig_b | input | 1 | Conversion-end trigger B |
| pwm_irq | input | 1 | PWM interrupt for overrun detection |
| task_done | input | 16 | Per-task completion strobes |
| task_start | output | 16 | Per-task start strobes |
| sched_irq | output | 1 | Schedule-end interrupt pulse |
| task_irq | output | 1 | Task-end interrupt pulse |
| err_flag | output | 1 | Sticky overrun flag |
| dbg_pulse | output | 1 | Task transition marker |

## Verification
A corrupted pending list or phase state shows at the ports on the next start strobe: a task number appears out of order, is skipped, or is issued twice. A corrupted repeat count shows only at the end of the final input phase, when `sched_irq` comes one pass early or late. A lost "task running" bit shows within one cycle as a second start strobe before the awaited done. The reference model is compared on every clock, so each of these faults is reported in the first cycle in which it becomes visible.

// File: rtl/sched_seq_pkg.sv
package sched_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OUT  = 2'd1,
        ST_WAIT = 2'd2,
        ST_IN   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sched_task_map.sv
// Turns a schedule value into the output-phase and input-phase task masks.
module sched_task_map #(
    parameter int NUM_TASKS = 16,
    parameter int SEL_W     = 4,
    parameter int ID_W      = $clog2(NUM_TASKS)
) (
    input  logic [SEL_W-1:0]     sched,
    input  logic [ID_W-1:0]      single_task,
    output logic [NUM_TASKS-1:0] out_mask,
    output logic [NUM_TASKS-1:0] in_mask
);
    localparam int IN_BASE   = NUM_TASKS / 2;
    localparam int FIXED_OFS = SEL_W;

    logic [NUM_TASKS-1:0] list_out;
    logic [NUM_TASKS-1:0] list_in;

    always_comb begin
        list_out = '0;
        list_in  = '0;
        for (int b = 0; b < SEL_W; b++) begin
            list_out[b]           = sched[b];
            list_in[IN_BASE + b]  = sched[b];
        end
        list_out[FIXED_OFS]           = 1'b1;
        list_in[IN_BASE + FIXED_OFS]  = 1'b1;
    end

    always_comb begin
        if (sched == '0) begin
            out_mask = NUM_TASKS'(1) << single_task;
            in_mask  = '0;
        end else begin
            out_mask = list_out;
            in_mask  = list_in;
        end
    end

endmodule

// File: rtl/sched_task_pick.sv
// Lowest-numbered pending task.
module sched_task_pick #(
    parameter int NUM_TASKS = 16,
    parameter int ID_W      = $clog2(NUM_TASKS)
) (
    input  logic [NUM_TASKS-1:0] pending,
    output logic                 found,
    output logic [ID_W-1:0]      idx
);
    always_comb begin
        found = |pending;
        idx   = '0;
        for (int i = NUM_TASKS - 1; i >= 0; i--) begin
            if (pending[i]) idx = ID_W'(i);
        end
    end
endmodule

// File: rtl/sched_seq.sv
module sched_seq
    import sched_seq_pkg::*;
#(
    parameter int NUM_TASKS     = 16,
    parameter int SEL_W         = 4,
    parameter int REP_W         = 4,
    parameter int ONE_PASS_FROM = 10,
    parameter int ID_W          = $clog2(NUM_TASKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_enable,
    input  logic [SEL_W-1:0]     cfg_sched,
    input  logic [ID_W-1:0]      cfg_task,
    input  logic [REP_W-1:0]     cfg_repeat,
    input  logic                 cfg_trig_sel,
    input  logic                 cfg_err_en,
    input  logic                 cfg_tirq_en,
    input  logic [ID_W-1:0]      cfg_tirq_task,
    input  logic                 err_clr,
    input  logic                 run_cmd,
    input  logic                 trig_a,
    input  logic                 trig_b,
    input  logic                 pwm_irq,
    input  logic [NUM_TASKS-1:0] task_done,
    output logic [NUM_TASKS-1:0] task_start,
    output logic                 sched_irq,
    output logic                 task_irq,
    output logic                 err_flag,
    output logic                 dbg_pulse
);
    typedef struct packed {
        seq_state_e            st;
        logic [NUM_TASKS-1:0]  pend;
        logic [ID_W-1:0]       cur;
        logic                  act;
        logic [REP_W-1:0]      reps;
        logic [SEL_W-1:0]      sched;
        logic [ID_W-1:0]       task_id;
        logic [NUM_TASKS-1:0]  start;
        logic                  sirq;
        logic                  tirq;
        logic                  dbg;
        logic                  err;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [SEL_W-1:0]     map_sched;
    logic [ID_W-1:0]      map_task;
    logic [NUM_TASKS-1:0] map_out, map_in;
    logic                 pick_found;
    logic [ID_W-1:0]      pick_idx;
    logic [NUM_TASKS-1:0] pick_hot;
    logic                 trig_hit;
    logic                 one_pass;

    assign map_sched = (r_q.st == ST_IDLE) ? cfg_sched : r_q.sched;
    assign map_task  = (r_q.st == ST_IDLE) ? cfg_task  : r_q.task_id;

    sched_task_map #(.NUM_TASKS(NUM_TASKS), .SEL_W(SEL_W), .ID_W(ID_W)) u_map (
        .sched       (map_sched),
        .single_task (map_task),
        .out_mask    (map_out),
        .in_mask     (map_in)
    );

    sched_task_pick #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W)) u_pick (
        .pending (r_q.pend),
        .found   (pick_found),
        .idx     (pick_idx)
    );

    assign pick_hot = NUM_TASKS'(1) << pick_idx;
    assign trig_hit = cfg_trig_sel ? trig_b : trig_a;
    assign one_pass = (cfg_sched == '0) || (cfg_sched >= SEL_W'(ONE_PASS_FROM));

    always_comb begin
        r_d       = r_q;
        r_d.start = '0;
        r_d.sirq  = 1'b0;
        r_d.tirq  = 1'b0;
        r_d.dbg   = 1'b0;
        if (err_clr) r_d.err = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (run_cmd && cfg_enable && (cfg_repeat != '0)) begin
                    r_d.st      = ST_OUT;
                    r_d.pend    = map_out;
                    r_d.act     = 1'b0;
                    r_d.reps    = one_pass ? REP_W'(1) : cfg_repeat;
                    r_d.sched   = cfg_sched;
                    r_d.task_id = cfg_task;
                end
            end
            ST_OUT, ST_IN: begin
                if ((r_q.st == ST_OUT) && cfg_err_en && pwm_irq) begin
                    r_d.sirq = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.st   = ST_IDLE;
                    r_d.pend = '0;
                    r_d.act  = 1'b0;
                end else if (r_q.act) begin
                    if (task_done[r_q.cur]) begin
                        r_d.act = 1'b0;
                        if (cfg_tirq_en && (r_q.cur == cfg_tirq_task)) r_d.tirq = 1'b1;
                    end
                end else if (pick_found) begin
                    r_d.start = pick_hot;
                    r_d.dbg   = 1'b1;
                    r_d.cur   = pick_idx;
                    r_d.act   = 1'b1;
                    r_d.pend  = r_q.pend & ~pick_hot;
                end else if (r_q.st == ST_OUT) begin
                    if (r_q.sched == '0) begin
                        r_d.sirq = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.st = ST_WAIT;
                    end
                end else begin
                    if (r_q.reps == REP_W'(1)) begin
                        r_d.sirq = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.reps = r_q.reps - REP_W'(1);
                        r_d.st   = ST_OUT;
                        r_d.pend = map_out;
                    end
                end
            end
            ST_WAIT: begin
                if (trig_hit) begin
                    r_d.st   = ST_IN;
                    r_d.pend = map_in;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign task_start = r_q.start;
    assign sched_irq  = r_q.sirq;
    assign task_irq   = r_q.tirq;
    assign err_flag   = r_q.err;
    assign dbg_pulse  = r_q.dbg;

    p_run_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && (!cfg_enable || cfg_repeat == '0)) |=> (r_q.st == ST_IDLE));

    p_start_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(task_start));

    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.act && !task_done[r_q.cur]) |=> (task_start == '0));

    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && !trig_hit) |=> (r_q.st == ST_WAIT));

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(r_q.st == ST_OUT && pwm_irq && cfg_err_en));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    p_sirq_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sched_irq |=> !sched_irq);

    p_tirq_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        task_irq |=> !task_irq);

endmodule

// File: tb/sched_seq_bench.sv
`timescale 1ns/1ps
module sched_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [3:0]  cfg_sched = '0;
    logic [3:0]  cfg_task = '0;
    logic [3:0]  cfg_repeat = '0;
    logic        cfg_trig_sel = 1'b0;
    logic        cfg_err_en = 1'b0;
    logic        cfg_tirq_en = 1'b0;
    logic [3:0]  cfg_tirq_task = '0;
    logic        err_clr = 1'b0;
    logic        run_cmd = 1'b0;
    logic        trig_a = 1'b0;
    logic        trig_b = 1'b0;
    logic        pwm_irq = 1'b0;
    logic [15:0] task_done = '0;
    logic [15:0] task_start;
    logic        sched_irq, task_irq, err_flag, dbg_pulse;

    always #4 clk = ~clk;

    sched_seq u_sched_seq (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sched(cfg_sched),
        .cfg_task(cfg_task), .cfg_repeat(cfg_repeat), .cfg_trig_sel(cfg_trig_sel),
        .cfg_err_en(cfg_err_en), .cfg_tirq_en(cfg_tirq_en), .cfg_tirq_task(cfg_tirq_task),
        .err_clr(err_clr), .run_cmd(run_cmd), .trig_a(trig_a), .trig_b(trig_b),
        .pwm_irq(pwm_irq), .task_done(task_done), .task_start(task_start),
        .sched_irq(sched_irq), .task_irq(task_irq), .err_flag(err_flag), .dbg_pulse(dbg_pulse)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_st = 0;          // 0 idle, 1 output, 2 waiting, 3 input
    int  m_q[$];
    int  m_cur = 0;
    bit  m_act = 0;
    int  m_reps = 0;
    int  m_s = 0;
    int  m_t = 0;
    logic [15:0] e_start = '0;
    bit  e_sirq = 0, e_tirq = 0, e_dbg = 0, e_err = 0;

    task automatic load_out();
        m_q.delete();
        if (m_s == 0) m_q.push_back(m_t);
        else begin
            for (int b = 0; b < 4; b++) if (((m_s >> b) & 1) == 1) m_q.push_back(b);
            m_q.push_back(4);
        end
    endtask

    task automatic load_in();
        m_q.delete();
        for (int b = 0; b < 4; b++) if (((m_s >> b) & 1) == 1) m_q.push_back(8 + b);
        m_q.push_back(12);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_q.delete(); m_act = 0; m_cur = 0; m_reps = 0;
            e_start = '0; e_sirq = 0; e_tirq = 0; e_dbg = 0; e_err = 0;
        end else begin
            e_start = '0; e_sirq = 0; e_tirq = 0; e_dbg = 0;
            if (err_clr) e_err = 0;
            if (m_st == 0) begin
                if (run_cmd && cfg_enable && cfg_repeat != 0) begin
                    m_s = int'(cfg_sched); m_t = int'(cfg_task);
                    load_out();
                    m_reps = (m_s == 0 || m_s >= 10) ? 1 : int'(cfg_repeat);
                    m_act = 0; m_st = 1;
                end
            end else if (m_st == 2) begin
                if (cfg_trig_sel ? trig_b : trig_a) begin load_in(); m_st = 3; end
            end else begin
                if (m_st == 1 && cfg_err_en && pwm_irq) begin
                    e_sirq = 1; e_err = 1; m_st = 0; m_act = 0; m_q.delete();
                end else if (m_act) begin
                    if (task_done[m_cur]) begin
                        m_act = 0;
                        if (cfg_tirq_en && m_cur == int'(cfg_tirq_task)) e_tirq = 1;
                    end
                end else if (m_q.size() > 0) begin
                    m_cur = m_q.pop_front();
                    e_start[m_cur] = 1'b1; e_dbg = 1; m_act = 1;
                end else if (m_st == 1) begin
                    if (m_s == 0) begin e_sirq = 1; m_st = 0; end
                    else m_st = 2;
                end else begin
                    if (m_reps == 1) begin e_sirq = 1; m_st = 0; end
                    else begin m_reps--; load_out(); m_st = 1; end
                end
            end
        end
    end

    // ---------------- per-clock comparison and observation ----------------
    int obs[$];
    int n_sirq = 0, n_tirq = 0, n_dbg = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R4", "task_start", int'(task_start), int'(e_start));
            check("R6", "sched_irq", int'(sched_irq), int'(e_sirq));
            check("R10", "task_irq", int'(task_irq), int'(e_tirq));
            check("R9", "err_flag", int'(err_flag), int'(e_err));
            check("R11", "dbg_pulse", int'(dbg_pulse), int'(e_dbg));
            for (int k = 0; k < 16; k++) if (task_start[k]) obs.push_back(k);
            n_sirq += int'(sched_irq);
            n_tirq += int'(task_irq);
            n_dbg  += int'(dbg_pulse);
        end
    end

    // ---------------- task unit responder ----------------
    int lat_cnt[16];
    initial for (int k = 0; k < 16; k++) lat_cnt[k] = 0;

    always @(negedge clk) begin
        task_done <= '0;
        for (int k = 0; k < 16; k++) begin
            if (lat_cnt[k] > 0) begin
                lat_cnt[k] = lat_cnt[k] - 1;
                if (lat_cnt[k] == 0) task_done[k] <= 1'b1;
            end
            if (task_start[k]) lat_cnt[k] = 1 + (k % 3);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic clear_obs();
        obs.delete(); n_sirq = 0; n_tirq = 0; n_dbg = 0;
    endtask

    task automatic run_sched(int s, int t, int rep, bit sel, bit wrong_first, int pwm_at);
        bit wrong_done = 0;
        int cyc = 0;
        cfg_sched = 4'(s); cfg_task = 4'(t); cfg_repeat = 4'(rep); cfg_trig_sel = sel;
        @(negedge clk); run_cmd = 1'b1;
        @(negedge clk); run_cmd = 1'b0;
        while (cyc < 3000) begin
            @(negedge clk);
            trig_a = 1'b0; trig_b = 1'b0; pwm_irq = 1'b0;
            cyc++;
            if (cyc == pwm_at) pwm_irq = 1'b1;
            if (m_st == 0) break;
            if (m_st == 2) begin
                if (wrong_first && !wrong_done) begin
                    if (sel) trig_a = 1'b1; else trig_b = 1'b1;
                    wrong_done = 1;
                end else begin
                    if (sel) trig_b = 1'b1; else trig_a = 1'b1;
                end
            end
        end
        trig_a = 1'b0; trig_b = 1'b0; pwm_irq = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_list(string req, int exp[]);
        check(req, "start count", obs.size(), exp.size());
        for (int i = 0; i < exp.size() && i < obs.size(); i++)
            check(req, $sformatf("start #%0d", i), obs[i], exp[i]);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12", "reset task_start", int'(task_start), 0);
        check("R12", "reset sched_irq", int'(sched_irq), 0);
        check("R12", "reset task_irq", int'(task_irq), 0);
        check("R12", "reset err_flag", int'(err_flag), 0);
        check("R12", "reset dbg_pulse", int'(dbg_pulse), 0);

        // R1: disabled block ignores the run command
        clear_obs();
        cfg_enable = 1'b0; cfg_sched = 4'd1; cfg_repeat = 4'd1;
        @(negedge clk); run_cmd = 1'b1; @(negedge clk); run_cmd = 1'b0;
        repeat (12) @(negedge clk);
        check("R1", "starts while disabled", obs.size(), 0);
        // R1: repeat 0 never runs
        cfg_enable = 1'b1; cfg_repeat = 4'd0;
        @(negedge clk); run_cmd = 1'b1; @(negedge clk); run_cmd = 1'b0;
        repeat (12) @(negedge clk);
        check("R1", "starts with repeat 0", obs.size(), 0);
        check("R1", "irq with repeat 0", n_sirq, 0);

        // R3: single task mode, repeat ignored
        clear_obs();
        run_sched(0, 6, 5, 1'b0, 1'b0, -1);
        check_list("R3", '{6});
        check("R3", "sched_irq count", n_sirq, 1);

        // R2 R5 R6: schedule 5, two passes, wrong trigger first
        clear_obs();
        run_sched(5, 0, 2, 1'b0, 1'b1, -1);
        check_list("R2", '{0, 2, 4, 8, 10, 12, 0, 2, 4, 8, 10, 12});
        check("R6", "sched_irq after two passes", n_sirq, 1);
        check("R5", "unselected trigger kept waiting", obs.size(), 12);

        // R7: schedule 11, repeat 3 gives one pass; pwm with detection off (R8)
        clear_obs();
        cfg_err_en = 1'b0;
        run_sched(11, 0, 3, 1'b1, 1'b1, 3);
        check_list("R7", '{0, 1, 3, 4, 8, 9, 11, 12});
        check("R7", "sched_irq count", n_sirq, 1);
        check("R8", "pwm ignored when disarmed", int'(err_flag), 0);

        // R10 R11: task-end interrupt on task 9 in schedule 3
        clear_obs();
        cfg_tirq_en = 1'b1; cfg_tirq_task = 4'd9;
        run_sched(3, 0, 1, 1'b0, 1'b0, -1);
        check_list("R2", '{0, 1, 4, 8, 9, 12});
        check("R10", "task_irq count", n_tirq, 1);
        check("R11", "dbg pulses equal starts", n_dbg, obs.size());
        cfg_tirq_en = 1'b0;

        // R8: overrun abort during output phase
        clear_obs();
        cfg_err_en = 1'b1;
        run_sched(6, 0, 2, 1'b0, 1'b0, 3);
        check("R8", "starts before abort", obs.size(), 1);
        check("R8", "sched_irq on abort", n_sirq, 1);
        check("R8", "err_flag set", int'(err_flag), 1);
        // R8/R9: pwm while idle has no effect and flag stays
        clear_obs();
        @(negedge clk); pwm_irq = 1'b1; @(negedge clk); pwm_irq = 1'b0;
        repeat (5) @(negedge clk);
        check("R8", "idle pwm no irq", n_sirq, 0);
        check("R9", "flag still set", int'(err_flag), 1);
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        @(negedge clk);
        check("R9", "flag cleared", int'(err_flag), 0);
        // R12: no back-to-back interrupt pulses observed across the run (model compare covers)
        check("R12", "irq idle", int'(sched_irq), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule